// File: doc/BRIEF.md
# Masked-Write Clock and Reset Control Bank

This block is a small bank of memory-mapped control registers that drives per-peripheral clock-enable, clock-gating-enable and reset lines. Each 32-bit register carries sixteen control bits in its lower half. The upper half of every write is a per-bit write enable for those bits. Software can therefore set or clear one peripheral's bit in a single write, with no read-modify-write sequence and no risk of disturbing a neighbour's bit.

The bank has three groups of ten registers: clock enables, clock-gating enables and block resets. It also has a read-only revision stamp. All register bits appear on three flat output vectors, sixteen bits per register, in register order. Access is over a plain single-cycle register bus. A write takes effect at the next clock edge. Read data is combinational from the current register contents.

Top module: `clkrst_ctrl_bank`

## Requirements
- R1: On a write, control bit i (0..15) of the addressed register takes the value of bus_wdata[i] when bus_wdata[16+i] is 1, and keeps its value when bus_wdata[16+i] is 0. For example, 0x00010001 sets bit 0 and 0x00010000 clears bit 0.
- R2: A write whose upper half bus_wdata[31:16] is all zero leaves every output bit unchanged.
- R3: A read of any clock, gating or reset register returns its sixteen control bits in [15:0] and zero in [31:16]. Read data is combinational, so a read in the same cycle as a write to that register returns the value from before the write.
- R4: Word index 0 (byte address 0x00) reads the fixed revision stamp, 0x5A170C03 by default, and writes to it have no effect on any output or read value.
- R5: Byte address 4*k selects word index k. Indices 1..10 drive clk_en_o, indices 11..20 drive gate_en_o and indices 21..30 drive rst_o. Register index b+j drives bits [16*j+15 : 16*j] of its group's vector.
- R6: While rst_n is low, and until the first write after it rises, every bit of clk_en_o, gate_en_o and rst_o is 1. Every block thus starts clocked and held in reset.
- R7: Word index 31 is unused. It reads as zero, and writes to it leave all outputs unchanged.
- R8: Outputs change only on the rising clock edge that samples a write strobe (bus_sel and bus_we both 1). In all other cycles they hold their value.
- R9: With bus_sel low, bus_we and bus_wdata have no effect.
- R10: A clock-enable bit of 1 enables its block's clock. A reset bit of 1 holds its block in reset. The bench releases a reset by writing its bit to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 7 | Byte address; bits [6:2] are the word index |
| bus_wdata | input | 32 | Write data: [31:16] mask, [15:0] values |
| bus_rdata | output | 32 | Combinational read data |
| clk_en_o | output | 160 | Clock enables, 16 per register |
| gate_en_o | output | 160 | Clock-gating enables, 16 per register |
| rst_o | output | 160 | Block resets, active high |

## Verification
A write presented at one falling edge is sampled at the next rising edge, and its effect on the output vectors is due one register stage later. The bench therefore checks the outputs at the following falling edge. Read data has no register stage, so the bench checks it 1 ns after the address is driven, in the same cycle. During a write this gives the value from before the write. The bench runs the directed corner cases and then a seeded random mix of reads, writes, unused-index writes and deselected writes. After every operation it compares all three output vectors against its own model.

// File: rtl/clkrst_pkg.sv
package clkrst_pkg;
  // Which region of the map a word index falls into
  typedef enum logic [2:0] {
    GRP_NONE,
    GRP_STAMP,
    GRP_CLK,
    GRP_GATE,
    GRP_RST
  } grp_e;
endpackage

// File: rtl/clkrst_decode.sv
module clkrst_decode
  import clkrst_pkg::*;
#(
  parameter int N         = 10,
  parameter int IDX_W     = 5,
  parameter int CLK_BASE  = 1,
  parameter int GATE_BASE = 11,
  parameter int RST_BASE  = 21
) (
  input  logic [IDX_W-1:0] idx,
  input  logic             wr_stb,
  output grp_e             grp,
  output logic [IDX_W-1:0] slot,
  output logic [N-1:0]     wr_clk,
  output logic [N-1:0]     wr_gate,
  output logic [N-1:0]     wr_rst
);
  localparam logic [IDX_W-1:0] CB = IDX_W'(CLK_BASE);
  localparam logic [IDX_W-1:0] CE = IDX_W'(CLK_BASE + N - 1);
  localparam logic [IDX_W-1:0] GB = IDX_W'(GATE_BASE);
  localparam logic [IDX_W-1:0] GE = IDX_W'(GATE_BASE + N - 1);
  localparam logic [IDX_W-1:0] RB = IDX_W'(RST_BASE);
  localparam logic [IDX_W-1:0] RE = IDX_W'(RST_BASE + N - 1);

  always_comb begin
    grp  = GRP_NONE;
    slot = '0;
    if (idx == '0) begin
      grp = GRP_STAMP;
    end else if (idx >= CB && idx <= CE) begin
      grp  = GRP_CLK;
      slot = idx - CB;
    end else if (idx >= GB && idx <= GE) begin
      grp  = GRP_GATE;
      slot = idx - GB;
    end else if (idx >= RB && idx <= RE) begin
      grp  = GRP_RST;
      slot = idx - RB;
    end
  end

  for (genvar j = 0; j < N; j++) begin : g_stb
    logic hit;
    assign hit        = wr_stb && (slot == IDX_W'(j));
    assign wr_clk[j]  = hit && (grp == GRP_CLK);
    assign wr_gate[j] = hit && (grp == GRP_GATE);
    assign wr_rst[j]  = hit && (grp == GRP_RST);
  end
endmodule

// File: rtl/clkrst_group.sv
module clkrst_group #(
  parameter int   N       = 10,
  parameter int   W       = 16,
  parameter logic RST_BIT = 1'b1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] wr,
  input  logic [W-1:0] wbits,
  input  logic [W-1:0] wmask,
  output logic [N*W-1:0] q
);
  for (genvar j = 0; j < N; j++) begin : g_reg
    logic [W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        r <= {W{RST_BIT}};
      end else if (wr[j]) begin
        r <= (r & ~wmask) | (wbits & wmask);
      end
    end
    assign q[j*W +: W] = r;
  end
endmodule

// File: rtl/clkrst_rdmux.sv
module clkrst_rdmux
  import clkrst_pkg::*;
#(
  parameter int            N     = 10,
  parameter int            W     = 16,
  parameter int            IDX_W = 5,
  parameter logic [2*W-1:0] STAMP = '0
) (
  input  grp_e             grp,
  input  logic [IDX_W-1:0] slot,
  input  logic [N*W-1:0]   clk_q,
  input  logic [N*W-1:0]   gate_q,
  input  logic [N*W-1:0]   rst_q,
  output logic [2*W-1:0]   rdata
);
  logic [W-1:0] pick;

  always_comb begin
    pick = '0;
    for (int j = 0; j < N; j++) begin
      if (slot == IDX_W'(j)) begin
        case (grp)
          GRP_CLK:  pick = clk_q[j*W +: W];
          GRP_GATE: pick = gate_q[j*W +: W];
          GRP_RST:  pick = rst_q[j*W +: W];
          default:  pick = '0;
        endcase
      end
    end
  end

  always_comb begin
    case (grp)
      GRP_STAMP: rdata = STAMP;
      GRP_NONE:  rdata = '0;
      default:   rdata = {{W{1'b0}}, pick};
    endcase
  end
endmodule

// File: rtl/clkrst_ctrl_bank.sv
module clkrst_ctrl_bank
  import clkrst_pkg::*;
#(
  parameter int                    GROUP_REGS = 10,
  parameter int                    CTRL_W     = 16,
  parameter int                    ADDR_W     = 7,
  parameter logic [2*CTRL_W-1:0]   STAMP_VAL  = 32'h5A17_0C03
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         bus_sel,
  input  logic                         bus_we,
  input  logic [ADDR_W-1:0]            bus_addr,
  input  logic [2*CTRL_W-1:0]          bus_wdata,
  output logic [2*CTRL_W-1:0]          bus_rdata,
  output logic [GROUP_REGS*CTRL_W-1:0] clk_en_o,
  output logic [GROUP_REGS*CTRL_W-1:0] gate_en_o,
  output logic [GROUP_REGS*CTRL_W-1:0] rst_o
);
  localparam int IDX_W     = ADDR_W - 2;
  localparam int CLK_BASE  = 1;
  localparam int GATE_BASE = CLK_BASE + GROUP_REGS;
  localparam int RST_BASE  = GATE_BASE + GROUP_REGS;

  logic [IDX_W-1:0]      idx;
  logic                  wr_stb;
  grp_e                  grp;
  logic [IDX_W-1:0]      slot;
  logic [GROUP_REGS-1:0] wr_clk, wr_gate, wr_rst;
  logic [CTRL_W-1:0]     wbits, wmask;
  logic                  unused_lsb;

  assign idx        = bus_addr[ADDR_W-1:2];
  assign unused_lsb = ^bus_addr[1:0];
  assign wr_stb     = bus_sel && bus_we;
  assign wbits      = bus_wdata[CTRL_W-1:0];
  assign wmask      = bus_wdata[2*CTRL_W-1:CTRL_W];

  clkrst_decode #(
    .N(GROUP_REGS), .IDX_W(IDX_W), .CLK_BASE(CLK_BASE),
    .GATE_BASE(GATE_BASE), .RST_BASE(RST_BASE)
  ) u_dec (
    .idx(idx), .wr_stb(wr_stb), .grp(grp), .slot(slot),
    .wr_clk(wr_clk), .wr_gate(wr_gate), .wr_rst(wr_rst)
  );

  clkrst_group #(.N(GROUP_REGS), .W(CTRL_W), .RST_BIT(1'b1)) u_clk (
    .clk(clk), .rst_n(rst_n), .wr(wr_clk), .wbits(wbits), .wmask(wmask), .q(clk_en_o)
  );

  clkrst_group #(.N(GROUP_REGS), .W(CTRL_W), .RST_BIT(1'b1)) u_gate (
    .clk(clk), .rst_n(rst_n), .wr(wr_gate), .wbits(wbits), .wmask(wmask), .q(gate_en_o)
  );

  clkrst_group #(.N(GROUP_REGS), .W(CTRL_W), .RST_BIT(1'b1)) u_rst (
    .clk(clk), .rst_n(rst_n), .wr(wr_rst), .wbits(wbits), .wmask(wmask), .q(rst_o)
  );

  clkrst_rdmux #(
    .N(GROUP_REGS), .W(CTRL_W), .IDX_W(IDX_W), .STAMP(STAMP_VAL)
  ) u_rd (
    .grp(grp), .slot(slot), .clk_q(clk_en_o), .gate_q(gate_en_o),
    .rst_q(rst_o), .rdata(bus_rdata)
  );
endmodule

// File: rtl/clkrst_ctrl_bank_chk.sv
module clkrst_ctrl_bank_chk #(
  parameter int                  GROUP_REGS = 10,
  parameter int                  CTRL_W     = 16,
  parameter int                  ADDR_W     = 7,
  parameter logic [2*CTRL_W-1:0] STAMP_VAL  = 32'h5A17_0C03
) (
  input logic                         clk,
  input logic                         rst_n,
  input logic                         bus_sel,
  input logic                         bus_we,
  input logic [ADDR_W-1:0]            bus_addr,
  input logic [2*CTRL_W-1:0]          bus_wdata,
  input logic [2*CTRL_W-1:0]          bus_rdata,
  input logic [GROUP_REGS*CTRL_W-1:0] clk_en_o,
  input logic [GROUP_REGS*CTRL_W-1:0] gate_en_o,
  input logic [GROUP_REGS*CTRL_W-1:0] rst_o
);
  localparam int IDX_W    = ADDR_W - 2;
  localparam int W        = CTRL_W;
  localparam int RST_BASE = 1 + 2 * GROUP_REGS;

  logic [IDX_W-1:0] idx;
  logic             wr;
  assign idx = bus_addr[ADDR_W-1:2];
  assign wr  = bus_sel && bus_we;

  // R1
  clk_mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && idx == IDX_W'(1) |=> clk_en_o[W-1:0] ==
      (($past(clk_en_o[W-1:0]) & ~$past(bus_wdata[2*W-1:W])) |
       ($past(bus_wdata[W-1:0]) & $past(bus_wdata[2*W-1:W]))));

  // R5
  rst_mask_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && idx == IDX_W'(RST_BASE) |=> rst_o[W-1:0] ==
      (($past(rst_o[W-1:0]) & ~$past(bus_wdata[2*W-1:W])) |
       ($past(bus_wdata[W-1:0]) & $past(bus_wdata[2*W-1:W]))));

  // R8
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr |=> $stable(clk_en_o) && $stable(gate_en_o) && $stable(rst_o));

  // R2
  zero_mask_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr && bus_wdata[2*W-1:W] == '0 |=> $stable(clk_en_o) && $stable(gate_en_o) && $stable(rst_o));

  // R4
  stamp_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx == '0 |-> bus_rdata == STAMP_VAL);

  // R3
  upper_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx != '0 |-> bus_rdata[2*W-1:W] == '0);

  // R7
  unused_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
    idx == '1 |-> bus_rdata == '0);

  // R6
  reset_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (&clk_en_o) && (&gate_en_o) && (&rst_o));
endmodule

bind clkrst_ctrl_bank clkrst_ctrl_bank_chk #(
  .GROUP_REGS(GROUP_REGS), .CTRL_W(CTRL_W), .ADDR_W(ADDR_W), .STAMP_VAL(STAMP_VAL)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .clk_en_o(clk_en_o), .gate_en_o(gate_en_o), .rst_o(rst_o)
);

// File: tb/clkrst_ctrl_bank_test.sv
`timescale 1ns/1ps
module clkrst_ctrl_bank_test;
  localparam int          NR    = 10;
  localparam int          W     = 16;
  localparam int          FW    = NR * W;
  localparam logic [31:0] STAMP = 32'h5A17_0C03;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          bus_sel = 1'b0, bus_we = 1'b0;
  logic [6:0]    bus_addr = '0;
  logic [31:0]   bus_wdata = '0;
  logic [31:0]   bus_rdata;
  logic [FW-1:0] clk_en_o, gate_en_o, rst_o;

  int  n_chk = 0, n_fail = 0;
  bit  done = 1'b0;

  logic [W-1:0] m_clk [NR];
  logic [W-1:0] m_gate[NR];
  logic [W-1:0] m_rst [NR];

  always #5 clk = ~clk;

  clkrst_ctrl_bank uut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .clk_en_o(clk_en_o), .gate_en_o(gate_en_o), .rst_o(rst_o)
  );

  task automatic chk(input bit ok, input string tag, input logic [FW-1:0] act, input logic [FW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [W-1:0] merge(input logic [W-1:0] old, input logic [31:0] d);
    return (old & ~d[31:16]) | (d[15:0] & d[31:16]);
  endfunction

  function automatic logic [31:0] exp_read(input int k);
    if (k == 0) return STAMP;
    if (k >= 1 && k <= 10) return {16'h0, m_clk[k-1]};
    if (k >= 11 && k <= 20) return {16'h0, m_gate[k-11]};
    if (k >= 21 && k <= 30) return {16'h0, m_rst[k-21]};
    return 32'h0;
  endfunction

  function automatic logic [FW-1:0] flat(input int g);
    logic [FW-1:0] v;
    for (int j = 0; j < NR; j++)
      v[j*W +: W] = (g == 0) ? m_clk[j] : (g == 1) ? m_gate[j] : m_rst[j];
    return v;
  endfunction

  task automatic check_outputs(input string tag);
    chk(clk_en_o == flat(0), {tag, " clk_en_o"}, clk_en_o, flat(0));
    chk(gate_en_o == flat(1), {tag, " gate_en_o"}, gate_en_o, flat(1));
    chk(rst_o == flat(2), {tag, " rst_o"}, rst_o, flat(2));
  endtask

  // write with same-cycle read check (R3), then output check one edge later (R8)
  task automatic do_write(input int k, input logic [31:0] d, input bit sel, input string tag);
    @(negedge clk);
    bus_sel = sel; bus_we = 1'b1; bus_addr = {5'(k), 2'b00}; bus_wdata = d;
    #1;
    if (sel) chk(bus_rdata == exp_read(k), "R3 read during write is old value",
                 FW'(bus_rdata), FW'(exp_read(k)));
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0;
    if (sel) begin
      if (k >= 1 && k <= 10) m_clk[k-1] = merge(m_clk[k-1], d);
      else if (k >= 11 && k <= 20) m_gate[k-11] = merge(m_gate[k-11], d);
      else if (k >= 21 && k <= 30) m_rst[k-21] = merge(m_rst[k-21], d);
    end
    check_outputs(tag);
  endtask

  task automatic do_read(input int k, input string tag);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = {5'(k), 2'b00};
    #1;
    chk(bus_rdata == exp_read(k), tag, FW'(bus_rdata), FW'(exp_read(k)));
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    for (int j = 0; j < NR; j++) begin
      m_clk[j] = '1; m_gate[j] = '1; m_rst[j] = '1;
    end
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    check_outputs("R6 during reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_outputs("R6 after reset");
    do_read(1, "R6 R3 clk reg reset read");
    do_read(0, "R4 stamp read");
    // R10: release block reset bit 0 of reset register 3, then reassert
    do_write(24, 32'h0001_0000, 1'b1, "R10 R1 release reset");
    do_write(24, 32'h0001_0001, 1'b1, "R10 R1 hold reset");
    // R1: single-bit clear/set in clock register 3
    do_write(3, 32'h0004_0000, 1'b1, "R1 clk bit clear");
    do_write(3, 32'h0004_0004, 1'b1, "R1 clk bit set");
    do_write(12, 32'hFFFF_A5C3, 1'b1, "R5 gate reg full write");
    do_read(12, "R5 R3 gate reg read");
    // R2: zero mask
    do_write(12, 32'h0000_0000, 1'b1, "R2 zero mask");
    do_write(30, 32'h0000_FFFF, 1'b1, "R2 zero mask values set");
    // R4: stamp write ignored
    do_write(0, 32'hFFFF_0000, 1'b1, "R4 stamp write ignored");
    do_read(0, "R4 stamp after write");
    // R7: unused index
    do_write(31, 32'hFFFF_0000, 1'b1, "R7 unused write ignored");
    do_read(31, "R7 unused read zero");
    // R9: deselected write
    do_write(5, 32'hFFFF_0000, 1'b0, "R9 deselected write ignored");
    do_read(5, "R9 reg after deselected write");
    // Random mix
    for (int i = 0; i < 400; i++) begin
      int k;
      logic [31:0] d;
      k = int'($urandom_range(0, 31));
      d = $urandom;
      if ($urandom_range(0, 3) == 0) d[31:16] = 16'h1 << $urandom_range(0, 15);
      case ($urandom_range(0, 5))
        0:       do_read(k, "R3 R5 random read");
        1:       do_write(k, d, 1'b0, "R9 random deselected");
        default: do_write(k, d, 1'b1, "R1 R5 random write");
      endcase
    end
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule